// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator

This block runs one external memory or I/O transfer for a 16-bit processor with a 20-bit address space. The address and the data share the same pins. A request carries several fields: read or write, memory or I/O, a 16-bit segment value with a 2-bit code naming the segment register, a 16-bit offset, write data and a byte/word size. When a request arrives, the block forms the physical address and then walks the pins through a fixed four-clock sequence. In the first clock it puts out the address. In the remaining clocks it puts out status and data.

The low sixteen pins are driven through a separate output and an output-enable, and the incoming value appears on its own input. A board-level tri-state buffer joins them into one shared bus. The four upper lines carry the high address bits in the first clock. After that they carry status: the segment code, the live interrupt-enable flag, and a bit that is always zero. The address strobe pulses high in the first clock only. The active-low high-byte enable is valid in that same clock and stays high afterwards. A memory/I-O line and a direction line mark the kind of cycle. Read data is captured at the end of the third clock and held on `rdata`. A one-clock `done` pulse marks the fourth clock.

Top module: `mux_bus_cycle_gen`

## Requirements
- R1: For a memory cycle, the physical address is `(segment << 4) + offset`. Only 20 bits are kept, so a carry out of bit 19 is dropped.
- R2: A request that is sampled while the block is idle starts a cycle on the next clock. The cycle lasts exactly four clocks (T1..T4). In T1, `ale` is 1, `ad_o` holds address bits 15..0, `ad_oe` is 1 and `ahs_o` holds address bits 19..16. `ale` is 0 in every other clock.
- R3: In T2..T4, `ahs_o[1:0]` carries the segment code (00 extra, 01 stack, 10 code, 11 data). `ahs_o[2]` follows the `int_en` input in that same clock, and `ahs_o[3]` is 0.
- R4: In T1, `bhe_n` is 0 for a word access. For a byte access it is the inverse of address bit 0. In T2..T4, `bhe_n` is 1.
- R5: From T1 through T4, `mio` is 1 for a memory cycle and 0 for an I/O cycle.
- R6: In T2..T4, `dtr` is 1 for a write and 0 for a read. In T1 it is 0.
- R7: In T2..T4, a write drives `wdata` on `ad_o` with `ad_oe` = 1. A read releases the bus (`ad_oe` = 0, `ad_o` = 0).
- R8: On a read, `ad_i` is sampled at the clock edge that ends T3. It appears on `rdata` from T4 on. `rdata` keeps that value through later write cycles.
- R9: An I/O cycle puts the offset on `ad_o` in T1 and drives address bits 19..16 to 0. The segment value is ignored.
- R10: `done` is 1 in T4 only. A request that is present during T1..T4 is ignored, and the cycle keeps its own fields. The earliest next cycle starts after one idle clock.
- R11: While idle, and after reset: `ad_o` = 0, `ad_oe` = 0, `ahs_o` = 0, `ale` = 0, `bhe_n` = 1, `mio` = 0, `dtr` = 0, `done` = 0 and `rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a cycle when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_seg_sel | input | 2 | Segment register code |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset or port address |
| req_wdata | input | 16 | Write data |
| int_en | input | 1 | Interrupt-enable flag, reported as status |
| ad_o | output | 16 | Low bus lines, driven value |
| ad_oe | output | 1 | Low bus output enable |
| ad_i | input | 16 | Low bus lines, sampled value |
| ahs_o | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch strobe, active high |
| bhe_n | output | 1 | High-byte enable, active low |
| mio | output | 1 | 1 = memory, 0 = I/O |
| dtr | output | 1 | 1 = data out (write) |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-clock pulse in the last clock |

## Verification
The patterns are chosen so that each one separates a pair of behaviours:
- **Reads and writes of words and bytes, at odd and even addresses:** separate the bus-release path from the data-drive path, and the two values of the high-byte enable.
- **A segment/offset pair whose sum passes 20 bits:** shows that the carry is dropped.
- **I/O cycles with a non-zero segment:** show that the segment is ignored and the upper lines are zero.
- **Toggling `int_en` in the middle of a cycle:** tells a live status bit apart from a captured one.
- **A request held high through a whole cycle, with its fields changed:** shows that the running cycle keeps its own fields and that no cycle starts until after the idle clock.

// File: rtl/mbc_pkg.sv
// Package: shared phase encoding and segment codes for the bus cycle generator.
// Assumes a cycle of exactly four clocks with no wait states.
package mbc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_e;

    localparam logic [1:0] SEG_EXTRA = 2'b00;
    localparam logic [1:0] SEG_STACK = 2'b01;
    localparam logic [1:0] SEG_CODE  = 2'b10;
    localparam logic [1:0] SEG_DATA  = 2'b11;

endpackage

// File: rtl/mbc_addr_gen.sv
// Address generator: forms the physical address from segment and offset,
// or a port address for I/O, and decides the high-byte enable for T1.
// Assumes ADDR_W == OFF_W + SEG_SHIFT; carries out of ADDR_W are dropped.
module mbc_addr_gen #(
    parameter int OFF_W     = 16,
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 4
) (
    input  logic [OFF_W-1:0]  seg_val,
    input  logic [OFF_W-1:0]  off_val,
    input  logic              is_io,
    input  logic              byte_xfer,
    output logic [ADDR_W-1:0] phys,
    output logic              hi_en_n
);
    localparam int UP_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] seg_shifted;
    logic [ADDR_W-1:0] mem_addr;

    // Shift the segment and add the zero-extended offset
    always_comb begin
        seg_shifted = ADDR_W'({seg_val, {SEG_SHIFT{1'b0}}});
        mem_addr    = seg_shifted + ADDR_W'(off_val);
    end

    // Pick memory or port address and the byte-lane enable
    always_comb begin
        phys    = is_io ? {{UP_W{1'b0}}, off_val} : mem_addr;
        hi_en_n = byte_xfer ? ~phys[0] : 1'b0;
    end
endmodule

// File: rtl/mbc_tseq.sv
// T-state sequencer: leaves idle on start and steps T1..T4, then back to idle.
// Assumes start is only meaningful while idle; it is ignored in other phases.
module mbc_tseq
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase
);
    // Advance one T-state per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: phase <= start ? PH_T1 : PH_IDLE;
                PH_T1:   phase <= PH_T2;
                PH_T2:   phase <= PH_T3;
                PH_T3:   phase <= PH_T4;
                PH_T4:   phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbc_pin_drive.sv
// Pin driver: decodes the current T-state and the captured request into the
// bus pins. Assumes UP_W == 4 so the upper lines can carry the status nibble.
module mbc_pin_drive
    import mbc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int UP_W = 4
) (
    input  phase_e              phase,
    input  logic [DW+UP_W-1:0]  phys_q,
    input  logic                hi_en_n_q,
    input  logic                write_q,
    input  logic                io_q,
    input  logic [1:0]          seg_sel_q,
    input  logic [DW-1:0]       wdata_q,
    input  logic                int_en,
    output logic [DW-1:0]       ad_o,
    output logic                ad_oe,
    output logic [UP_W-1:0]     ahs_o,
    output logic                ale,
    output logic                bhe_n,
    output logic                mio,
    output logic                dtr,
    output logic                done
);
    logic [UP_W-1:0] status_nib;
    logic            data_ph;

    // Status nibble: bit3 zero, bit2 live interrupt enable, bits1:0 segment code
    always_comb begin
        status_nib = UP_W'({1'b0, int_en, seg_sel_q});
        data_ph    = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_T4);
    end

    // Drive every pin from the phase
    always_comb begin
        ad_o  = '0;
        ad_oe = 1'b0;
        ahs_o = '0;
        ale   = 1'b0;
        bhe_n = 1'b1;
        mio   = 1'b0;
        dtr   = 1'b0;
        done  = 1'b0;
        if (phase == PH_T1) begin
            ad_o  = phys_q[DW-1:0];
            ad_oe = 1'b1;
            ahs_o = phys_q[DW+UP_W-1:DW];
            ale   = 1'b1;
            bhe_n = hi_en_n_q;
            mio   = ~io_q;
        end else if (data_ph) begin
            ad_o  = write_q ? wdata_q : '0;
            ad_oe = write_q;
            ahs_o = status_nib;
            mio   = ~io_q;
            dtr   = write_q;
            done  = (phase == PH_T4);
        end
    end
endmodule

// File: rtl/mux_bus_cycle_gen.sv
// Top: captures a request when idle, sequences T1..T4 and drives the
// multiplexed bus. Assumes no wait states and a single bus master.
module mux_bus_cycle_gen
    import mbc_pkg::*;
#(
    parameter int DW        = 16,
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_io,
    input  logic                 req_byte,
    input  logic [1:0]           req_seg_sel,
    input  logic [DW-1:0]        req_seg,
    input  logic [DW-1:0]        req_off,
    input  logic [DW-1:0]        req_wdata,
    input  logic                 int_en,
    output logic [DW-1:0]        ad_o,
    output logic                 ad_oe,
    input  logic [DW-1:0]        ad_i,
    output logic [ADDR_W-DW-1:0] ahs_o,
    output logic                 ale,
    output logic                 bhe_n,
    output logic                 mio,
    output logic                 dtr,
    output logic [DW-1:0]        rdata,
    output logic                 done
);
    localparam int UP_W = ADDR_W - DW;

    phase_e            phase;
    logic              start;
    logic [ADDR_W-1:0] phys_d;
    logic              hi_en_n_d;
    logic [ADDR_W-1:0] phys_q;
    logic              hi_en_n_q;
    logic              write_q;
    logic              io_q;
    logic [1:0]        seg_sel_q;
    logic [DW-1:0]     wdata_q;

    // Accept a request only while idle
    always_comb start = req_valid && (phase == PH_IDLE);

    mbc_addr_gen #(
        .OFF_W     (DW),
        .ADDR_W    (ADDR_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_addr (
        .seg_val   (req_seg),
        .off_val   (req_off),
        .is_io     (req_io),
        .byte_xfer (req_byte),
        .phys      (phys_d),
        .hi_en_n   (hi_en_n_d)
    );

    mbc_tseq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .phase (phase)
    );

    // Capture the request fields at the start of a cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_q    <= '0;
            hi_en_n_q <= 1'b1;
            write_q   <= 1'b0;
            io_q      <= 1'b0;
            seg_sel_q <= SEG_EXTRA;
            wdata_q   <= '0;
        end else if (start) begin
            phys_q    <= phys_d;
            hi_en_n_q <= hi_en_n_d;
            write_q   <= req_write;
            io_q      <= req_io;
            seg_sel_q <= req_seg_sel;
            wdata_q   <= req_wdata;
        end
    end

    // Sample read data at the edge that ends T3
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if ((phase == PH_T3) && !write_q) begin
            rdata <= ad_i;
        end
    end

    mbc_pin_drive #(
        .DW   (DW),
        .UP_W (UP_W)
    ) u_pins (
        .phase     (phase),
        .phys_q    (phys_q),
        .hi_en_n_q (hi_en_n_q),
        .write_q   (write_q),
        .io_q      (io_q),
        .seg_sel_q (seg_sel_q),
        .wdata_q   (wdata_q),
        .int_en    (int_en),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe),
        .ahs_o     (ahs_o),
        .ale       (ale),
        .bhe_n     (bhe_n),
        .mio       (mio),
        .dtr       (dtr),
        .done      (done)
    );
endmodule

// File: rtl/mbc_checker.sv
// Checker: temporal properties of the bus pins, bound to the top module.
// Assumes the top's internal phase signal is visible through the bind.
module mbc_checker
    import mbc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input phase_e     phase,
    input logic       ale,
    input logic       done,
    input logic       ad_oe,
    input logic       dtr,
    input logic       mio,
    input logic       bhe_n,
    input logic [3:0] ahs_o,
    input logic       int_en
);
    logic data_ph;
    always_comb data_ph = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_T4);

    assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_done_three_after_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ale, 3));

    assert_status_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_ph |-> (ahs_o[3] == 1'b0 && ahs_o[2] == int_en));

    assert_bhe_high_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_ph |-> bhe_n);

    assert_drive_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !ale) |-> dtr);

    assert_io_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !mio) |-> (ahs_o == 4'h0));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!ad_oe && !ale && !done && !dtr));
endmodule

bind mux_bus_cycle_gen mbc_checker u_mbc_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .ale    (ale),
    .done   (done),
    .ad_oe  (ad_oe),
    .dtr    (dtr),
    .mio    (mio),
    .bhe_n  (bhe_n),
    .ahs_o  (ahs_o),
    .int_en (int_en)
);

// File: tb/test_mux_bus_cycle_gen.sv
module test_mux_bus_cycle_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_io, req_byte, int_en;
    logic [1:0]  req_seg_sel;
    logic [15:0] req_seg, req_off, req_wdata, ad_i;
    logic [15:0] ad_o, rdata;
    logic        ad_oe, ale, bhe_n, mio, dtr, done;
    logic [3:0]  ahs_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;
    logic [15:0] last_rd = 16'h0;

    always #5 clk = ~clk;

    mux_bus_cycle_gen i_mux_bus_cycle_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_byte(req_byte), .req_seg_sel(req_seg_sel),
        .req_seg(req_seg), .req_off(req_off), .req_wdata(req_wdata),
        .int_en(int_en), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .ahs_o(ahs_o), .ale(ale), .bhe_n(bhe_n), .mio(mio), .dtr(dtr),
        .rdata(rdata), .done(done)
    );

    function automatic logic [25:0] pins();
        return {ad_o, ad_oe, ahs_o, ale, bhe_n, mio, dtr, done};
    endfunction

    localparam logic [25:0] IDLE_PINS = {16'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

    task automatic chk(input string tag, input logic [25:0] got, input logic [25:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pins got %h expected %h (time %0t)", tag, got, exp, $time);
        end
    endtask

    task automatic chk16(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: rdata got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference model of one cycle; called at a negedge while idle.
    task automatic run_cycle(input logic wr, input logic io, input logic bsz,
                             input logic [1:0] sel, input logic [15:0] seg,
                             input logic [15:0] off, input logic [15:0] wd,
                             input logic [15:0] rd, input logic ie,
                             input logic flip_ie, input logic hold_req);
        logic [19:0] p;
        logic [25:0] e;
        logic        ie_now;
        p = io ? {4'h0, off} : (({4'h0, seg} << 4) + {4'h0, off});
        req_valid = 1'b1; req_write = wr; req_io = io; req_byte = bsz;
        req_seg_sel = sel; req_seg = seg; req_off = off; req_wdata = wd;
        ad_i = rd; int_en = ie; ie_now = ie;
        @(negedge clk);
        if (hold_req) begin
            req_seg = ~seg; req_off = ~off; req_wdata = ~wd; req_write = ~wr;
            req_io = ~io; req_seg_sel = ~sel; req_byte = ~bsz;
        end else begin
            req_valid = 1'b0;
        end
        // T1: address phase (R1 address sum, R2 strobe, R4 lane enable, R5, R9)
        e = {p[15:0], 1'b1, p[19:16], 1'b1, (bsz ? ~p[0] : 1'b0), ~io, 1'b0, 1'b0};
        chk("R1 R2 R4 R5 R9 T1", pins(), e);
        for (int t = 2; t <= 4; t++) begin
            @(negedge clk);
            if (flip_ie && t == 3) begin
                ie_now = ~ie_now;
                int_en = ie_now;
                #1;
            end
            // Data phase (R3 status, R6 direction, R7 bus drive, R10 done)
            e = {(wr ? wd : 16'h0), wr, {1'b0, ie_now, sel}, 1'b0, 1'b1, ~io, wr, (t == 4)};
            chk("R3 R6 R7 R10 data phase", pins(), e);
        end
        if (!wr) last_rd = rd;
        chk16("R8 read capture/hold", rdata, last_rd);
        @(negedge clk);
        chk("R10 R11 idle after cycle", pins(), IDLE_PINS);
        req_valid = 1'b0;
        ad_i = 16'hDEAD;
        @(negedge clk);
        chk("R10 R11 idle gap", pins(), IDLE_PINS);
        chk16("R8 rdata held", rdata, last_rd);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !ended) begin
            ended = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0;
        req_byte = 1'b0; req_seg_sel = 2'b00; req_seg = 16'h0; req_off = 16'h0;
        req_wdata = 16'h0; int_en = 1'b0; ad_i = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset pins", pins(), IDLE_PINS);
        chk16("R11 reset rdata", rdata, 16'h0);
        // Memory word read, data segment
        run_cycle(1'b0, 1'b0, 1'b0, 2'b11, 16'h1234, 16'h5678, 16'h0000, 16'hBEEF, 1'b0, 1'b0, 1'b0);
        // Memory byte write at odd address, stack segment, interrupts enabled
        run_cycle(1'b1, 1'b0, 1'b1, 2'b01, 16'h2000, 16'h0013, 16'hA55A, 16'h0000, 1'b1, 1'b0, 1'b0);
        // Address wrap past 20 bits (R1), code segment word write
        run_cycle(1'b1, 1'b0, 1'b0, 2'b10, 16'hFFFF, 16'h0020, 16'h1357, 16'h0000, 1'b0, 1'b0, 1'b0);
        // I/O byte write at even port, non-zero segment ignored (R9)
        run_cycle(1'b1, 1'b1, 1'b1, 2'b00, 16'hF00F, 16'h8442, 16'h00C3, 16'h0000, 1'b1, 1'b0, 1'b0);
        // I/O word read with interrupt flag toggled mid-cycle (R3)
        run_cycle(1'b0, 1'b1, 1'b0, 2'b10, 16'h7777, 16'hFFFE, 16'h0000, 16'h6C6C, 1'b0, 1'b1, 1'b0);
        // Request held and altered through the cycle (R10)
        run_cycle(1'b0, 1'b0, 1'b0, 2'b01, 16'h0ABC, 16'h0101, 16'h0000, 16'h1111, 1'b1, 1'b0, 1'b1);
        // Memory byte read at even address, extra segment
        run_cycle(1'b0, 1'b0, 1'b1, 2'b00, 16'h4000, 16'h0200, 16'h0000, 16'h2468, 1'b1, 1'b1, 1'b0);
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule